// File: doc/BRIEF.md
# USB Host Controller Error and Interrupt Core

This block holds the command, status and interrupt state of a USB host controller. It screens transfer descriptors for signs of corruption, stops the schedule when the system bus reports a fault, records resume signalling, and drives one interrupt request line. Software reaches its registers through a simple word-wide read and write port.

Two error classes cannot be masked: descriptor corruption and system bus faults. Both always reach the interrupt line and both stop the controller. Resume signalling received during global suspend is reported through a maskable source. A second reset, the power-good reset, clears a small group of bits that must survive deep sleep: the global-suspend command, the resume status, the wake flag and the per-port state. The ordinary reset leaves that group alone.

Register map (word address on `reg_addr`): 0 command (bit 0 run, bit 1 global suspend), 1 status (bit 0 resume seen, bit 1 system error, bit 2 process error, bit 3 halted, bit 4 wake), 2 interrupt enable (bit 0 resume), 3 + p port p (bit 0 enabled, bit 1 port resume, bit 2 low-speed device, bit 3 suspended). Reads return the addressed word one cycle after the address is presented.

Top module: `usb_hc_irq_core`

## Requirements
- R1: When `chk_valid` is high, a process error is flagged unless the PID's upper nibble equals the bitwise complement of its lower nibble, the lower nibble is 1 (OUT), 9 (IN) or 13 (SETUP), and `chk_maxlen` is below 1280.
- R2: A process error clears run (command bit 0), sets halted (status bit 3) and sets status bit 2, all in the same cycle.
- R3: A pulse on `bus_parity_err`, `bus_master_abort` or `bus_target_abort` sets status bit 1 and clears run. The error takes priority over a write that sets run in the same cycle.
- R4: Status bits 1 and 2 drive `irq` high whatever the enable register holds.
- R5: `resume_in` sets status bit 0 only while global suspend (command bit 1) is set. That bit reaches `irq` only when enable bit 0 is set.
- R6: Writing 1 to status bits 0, 1, 2 or 4, or to port bit 1, clears that bit. Writing 0 leaves it unchanged. `irq` reflects the status one cycle later.
- R7: Halted is set on a `frame_end` pulse while run is 0. It is cleared by a command write that sets run.
- R8: `rst` leaves global suspend, status bits 0 and 4 and all port bits unchanged. `pwr_rst` clears all of them.
- R9: A `port_resume` pulse sets that port's bit 1 and status bit 4. `wake_req` follows status bit 4 ANDed with `wake_en` one cycle later. A port's low-speed bit follows `port_ls` only while the port is not suspended.
- R10: After reset, run is 0, halted is 1, every other status bit is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main synchronous reset, active high |
| pwr_rst | input | 1 | Power-good reset, active high; also resets the main domain |
| chk_valid | input | 1 | Descriptor check strobe |
| chk_pid | input | 8 | Descriptor packet identifier |
| chk_maxlen | input | LEN_W | Descriptor maximum length field |
| bus_parity_err | input | 1 | System bus parity error pulse |
| bus_master_abort | input | 1 | System bus master abort pulse |
| bus_target_abort | input | 1 | System bus target abort pulse |
| resume_in | input | 1 | Resume signalling seen on the bus |
| frame_end | input | 1 | End-of-frame pulse |
| port_resume | input | NPORT | Per-port resume pulses |
| port_ls | input | NPORT | Per-port low-speed device indication |
| wake_en | input | 1 | Wake on USB enabled |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| run_stop | output | 1 | Run state |
| halted | output | 1 | Halted state |
| gsusp | output | 1 | Global suspend command state |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | System wake request |

## Verification
The properties treat every bus fault, resume, port resume and frame-end input as a single-cycle pulse. They also assume that a same-cycle register write conflicts with an event only in the ways the priority rules define. The stimulus raises each pulse for exactly one clock and performs register writes in cycles that carry no event. Both resets are held together from time zero, and `port_ls` changes only away from the clock edge.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_CMD   = 0;
  localparam int REG_STS   = 1;
  localparam int REG_IEN   = 2;
  localparam int REG_PORT0 = 3;

  localparam int CMD_RUN   = 0;
  localparam int CMD_GSUSP = 1;

  localparam int STS_RSM   = 0;
  localparam int STS_SYS   = 1;
  localparam int STS_PROC  = 2;
  localparam int STS_HALT  = 3;
  localparam int STS_WAKE  = 4;

  localparam int IEN_RSM   = 0;

  localparam int PRT_EN    = 0;
  localparam int PRT_RSM   = 1;
  localparam int PRT_LS    = 2;
  localparam int PRT_SUSP  = 3;

  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_SETUP = 4'hD;
endpackage

// File: rtl/hcirq_desc_check.sv
module hcirq_desc_check
  import hcirq_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1280
) (
  input  logic             chk_valid,
  input  logic [7:0]       chk_pid,
  input  logic [LEN_W-1:0] chk_maxlen,
  output logic             fault
);
  logic pid_ok;
  logic len_ok;

  always_comb begin
    pid_ok = (chk_pid[7:4] == ~chk_pid[3:0]) &&
             (chk_pid[3:0] inside {PID_OUT, PID_IN, PID_SETUP});
    len_ok = chk_maxlen < LEN_W'(MAX_LEN);
    fault  = chk_valid && !(pid_ok && len_ok);
  end
endmodule

// File: rtl/hcirq_status.sv
module hcirq_status
  import hcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_fault,
  input  logic              bus_err,
  input  logic              frame_end,
  input  logic              wr_cmd,
  input  logic              wr_sts,
  input  logic              wr_ien,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              resume_sts,
  output logic              run,
  output logic              halted,
  output logic              syserr,
  output logic              procerr,
  output logic              resume_en,
  output logic              irq
);
  logic run_n, halt_n, sys_n, proc_n;

  always_comb begin
    run_n  = run;
    halt_n = halted;
    if (frame_end && !run) halt_n = 1'b1;
    if (wr_cmd) begin
      run_n = wr_data[CMD_RUN];
      if (wr_data[CMD_RUN]) halt_n = 1'b0;
    end
    if (bus_err) run_n = 1'b0;
    if (proc_fault) begin
      run_n  = 1'b0;
      halt_n = 1'b1;
    end
    sys_n  = (syserr  && !(wr_sts && wr_data[STS_SYS]))  || bus_err;
    proc_n = (procerr && !(wr_sts && wr_data[STS_PROC])) || proc_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      halted    <= 1'b1;
      syserr    <= 1'b0;
      procerr   <= 1'b0;
      resume_en <= 1'b0;
      irq       <= 1'b0;
    end else begin
      run     <= run_n;
      halted  <= halt_n;
      syserr  <= sys_n;
      procerr <= proc_n;
      if (wr_ien) resume_en <= wr_data[IEN_RSM];
      irq <= syserr || procerr || (resume_sts && resume_en);
    end
  end

  // R2: a descriptor fault stops and halts at once
  p_proc_halt_r2: assert property (@(posedge clk) disable iff (rst)
    proc_fault |=> (halted && !run && procerr));
  // R3: a bus fault removes run
  p_bus_stop_r3: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> (!run && syserr));
  // R4: unmaskable sources reach the line
  p_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    (syserr || procerr) |=> irq);
  // R5: masked resume stays silent
  p_resume_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (!resume_en && !syserr && !procerr) |=> !irq);
  // R7: idle frame end sets halted
  p_frame_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !run && !(wr_cmd && wr_data[CMD_RUN])) |=> halted);
endmodule

// File: rtl/hcirq_retained.sv
module hcirq_retained
  import hcirq_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              wr_cmd,
  input  logic              wr_sts,
  input  logic [NPORT-1:0]  wr_port,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              resume_in,
  input  logic [NPORT-1:0]  port_resume,
  input  logic [NPORT-1:0]  port_ls,
  input  logic              wake_en,
  output logic              gsusp,
  output logic              resume_sts,
  output logic              wake_sts,
  output logic              wake_req,
  output logic [NPORT-1:0]  port_en,
  output logic [NPORT-1:0]  port_rsm,
  output logic [NPORT-1:0]  port_lsp,
  output logic [NPORT-1:0]  port_susp
);
  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      gsusp      <= 1'b0;
      resume_sts <= 1'b0;
      wake_sts   <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      if (wr_cmd) gsusp <= wr_data[CMD_GSUSP];
      resume_sts <= (resume_sts && !(wr_sts && wr_data[STS_RSM])) ||
                    (resume_in && gsusp);
      wake_sts   <= (wake_sts && !(wr_sts && wr_data[STS_WAKE])) ||
                    (|port_resume);
      wake_req   <= wake_sts && wake_en;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (pwr_rst) begin
        port_en[p]   <= 1'b0;
        port_rsm[p]  <= 1'b0;
        port_lsp[p]  <= 1'b0;
        port_susp[p] <= 1'b0;
      end else begin
        if (wr_port[p]) begin
          port_en[p]   <= wr_data[PRT_EN];
          port_susp[p] <= wr_data[PRT_SUSP];
        end
        port_rsm[p] <= (port_rsm[p] && !(wr_port[p] && wr_data[PRT_RSM])) ||
                       port_resume[p];
        if (!port_susp[p]) port_lsp[p] <= port_ls[p];
      end
    end

    // R9: port resume is recorded on the port
    p_port_rsm_r9: assert property (@(posedge clk) disable iff (pwr_rst)
      port_resume[p] |=> port_rsm[p]);
  end

  // R9: any port resume raises the wake flag
  p_wake_set_r9: assert property (@(posedge clk) disable iff (pwr_rst)
    (|port_resume) |=> wake_sts);
  // R5: resume during global suspend is recorded
  p_resume_set_r5: assert property (@(posedge clk) disable iff (pwr_rst)
    (resume_in && gsusp) |=> resume_sts);
endmodule

// File: rtl/usb_hc_irq_core.sv
module usb_hc_irq_core
  import hcirq_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1280,
  parameter int ADDR_W  = $clog2(REG_PORT0 + NPORT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_rst,
  input  logic              chk_valid,
  input  logic [7:0]        chk_pid,
  input  logic [LEN_W-1:0]  chk_maxlen,
  input  logic              bus_parity_err,
  input  logic              bus_master_abort,
  input  logic              bus_target_abort,
  input  logic              resume_in,
  input  logic              frame_end,
  input  logic [NPORT-1:0]  port_resume,
  input  logic [NPORT-1:0]  port_ls,
  input  logic              wake_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              run_stop,
  output logic              halted,
  output logic              gsusp,
  output logic              irq,
  output logic              wake_req
);
  logic main_rst;
  logic proc_fault, bus_err;
  logic wr_cmd, wr_sts, wr_ien;
  logic [NPORT-1:0] wr_port;
  logic syserr, procerr, resume_en, resume_sts, wake_sts;
  logic [NPORT-1:0] port_en, port_rsm, port_lsp, port_susp;
  logic [DATA_W-1:0] rd_n;

  assign main_rst = rst || pwr_rst;
  assign bus_err  = bus_parity_err || bus_master_abort || bus_target_abort;
  assign wr_cmd   = reg_wr && (reg_addr == ADDR_W'(REG_CMD));
  assign wr_sts   = reg_wr && (reg_addr == ADDR_W'(REG_STS));
  assign wr_ien   = reg_wr && (reg_addr == ADDR_W'(REG_IEN));

  for (genvar p = 0; p < NPORT; p++) begin : g_wdec
    assign wr_port[p] = reg_wr && (reg_addr == ADDR_W'(REG_PORT0 + p));
  end

  hcirq_desc_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
    .chk_valid  (chk_valid),
    .chk_pid    (chk_pid),
    .chk_maxlen (chk_maxlen),
    .fault      (proc_fault)
  );

  hcirq_status u_sts (
    .clk        (clk),
    .rst        (main_rst),
    .proc_fault (proc_fault),
    .bus_err    (bus_err),
    .frame_end  (frame_end),
    .wr_cmd     (wr_cmd),
    .wr_sts     (wr_sts),
    .wr_ien     (wr_ien),
    .wr_data    (reg_wdata),
    .resume_sts (resume_sts),
    .run        (run_stop),
    .halted     (halted),
    .syserr     (syserr),
    .procerr    (procerr),
    .resume_en  (resume_en),
    .irq        (irq)
  );

  hcirq_retained #(.NPORT(NPORT)) u_ret (
    .clk         (clk),
    .pwr_rst     (pwr_rst),
    .wr_cmd      (wr_cmd),
    .wr_sts      (wr_sts),
    .wr_port     (wr_port),
    .wr_data     (reg_wdata),
    .resume_in   (resume_in),
    .port_resume (port_resume),
    .port_ls     (port_ls),
    .wake_en     (wake_en),
    .gsusp       (gsusp),
    .resume_sts  (resume_sts),
    .wake_sts    (wake_sts),
    .wake_req    (wake_req),
    .port_en     (port_en),
    .port_rsm    (port_rsm),
    .port_lsp    (port_lsp),
    .port_susp   (port_susp)
  );

  always_comb begin
    rd_n = '0;
    if (reg_addr == ADDR_W'(REG_CMD)) begin
      rd_n[CMD_RUN]   = run_stop;
      rd_n[CMD_GSUSP] = gsusp;
    end else if (reg_addr == ADDR_W'(REG_STS)) begin
      rd_n[STS_RSM]  = resume_sts;
      rd_n[STS_SYS]  = syserr;
      rd_n[STS_PROC] = procerr;
      rd_n[STS_HALT] = halted;
      rd_n[STS_WAKE] = wake_sts;
    end else if (reg_addr == ADDR_W'(REG_IEN)) begin
      rd_n[IEN_RSM] = resume_en;
    end
    for (int p = 0; p < NPORT; p++) begin
      if (reg_addr == ADDR_W'(REG_PORT0 + p)) begin
        rd_n[PRT_EN]   = port_en[p];
        rd_n[PRT_RSM]  = port_rsm[p];
        rd_n[PRT_LS]   = port_lsp[p];
        rd_n[PRT_SUSP] = port_susp[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (main_rst) reg_rdata <= '0;
    else          reg_rdata <= rd_n;
  end
endmodule

// File: tb/usb_hc_irq_core_tb.sv
module usb_hc_irq_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 2;
  localparam int LEN_W = 11;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1, pwr_rst = 1'b1;
  logic chk_valid = 1'b0;
  logic [7:0] chk_pid = '0;
  logic [LEN_W-1:0] chk_maxlen = '0;
  logic bus_parity_err = 1'b0, bus_master_abort = 1'b0, bus_target_abort = 1'b0;
  logic resume_in = 1'b0, frame_end = 1'b0;
  logic [NPORT-1:0] port_resume = '0, port_ls = '0;
  logic wake_en = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic run_stop, halted, gsusp, irq, wake_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hc_irq_core #(.NPORT(NPORT), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst),
    .chk_valid(chk_valid), .chk_pid(chk_pid), .chk_maxlen(chk_maxlen),
    .bus_parity_err(bus_parity_err), .bus_master_abort(bus_master_abort),
    .bus_target_abort(bus_target_abort), .resume_in(resume_in),
    .frame_end(frame_end), .port_resume(port_resume), .port_ls(port_ls),
    .wake_en(wake_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_stop(run_stop),
    .halted(halted), .gsusp(gsusp), .irq(irq), .wake_req(wake_req)
  );

  // kind 0: register read, 1: irq, 2: wake_req
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  // monitor: compares the item pushed before this edge with the result after it
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {15'b0, irq};
        default: act = {15'b0, wake_req};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_reg(input int a, input logic [15:0] e, input string tag);
    item_t it;
    reg_addr = ADDR_W'(a);
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_sig(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {15'b0, e}; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic desc(input logic [7:0] pid, input int len);
    chk_pid = pid; chk_maxlen = LEN_W'(len); chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: bus_parity_err = 1'b1;
      1: bus_master_abort = 1'b1;
      2: bus_target_abort = 1'b1;
      3: resume_in = 1'b1;
      4: frame_end = 1'b1;
      default: port_resume = 2'b01;
    endcase
    @(negedge clk);
    bus_parity_err = 1'b0; bus_master_abort = 1'b0; bus_target_abort = 1'b0;
    resume_in = 1'b0; frame_end = 1'b0; port_resume = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0; pwr_rst = 1'b0;

    // R10 reset state
    exp_reg(0, 16'h0000, "R10 cmd after reset");
    exp_reg(1, 16'h0008, "R10 status after reset");
    exp_sig(1, 1'b0, "R10 irq after reset");

    // R7 run clears halted
    wr(0, 16'h0001);
    exp_reg(1, 16'h0000, "R7 halted cleared by run");

    // R1 valid descriptors: OUT 0xE1 len 1279, SETUP 0x2D len 0
    desc(8'hE1, 1279);
    exp_reg(1, 16'h0000, "R1 valid OUT descriptor");
    desc(8'h2D, 0);
    exp_reg(1, 16'h0000, "R1 valid SETUP descriptor");

    // R1/R2 complement-correct but unsupported PID 0xD2
    desc(8'hD2, 8);
    exp_sig(1, 1'b1, "R4 irq from process error, enable clear");
    exp_reg(1, 16'h000C, "R2 process error and halted");
    exp_reg(0, 16'h0000, "R2 run cleared");
    // R6 writing zero keeps status
    wr(1, 16'h0000);
    exp_reg(1, 16'h000C, "R6 zero write no effect");
    wr(1, 16'h0004);
    exp_sig(1, 1'b0, "R6 irq drops after clear");
    exp_reg(1, 16'h0008, "R6 process error cleared");

    // R1 length at the limit with valid IN PID 0x69
    desc(8'h69, 1280);
    exp_reg(1, 16'h000C, "R1 length 1280 rejected");
    wr(1, 16'h0004);
    // R1 broken complement 0xF1
    desc(8'hF1, 4);
    exp_reg(1, 16'h000C, "R1 bad complement rejected");
    wr(1, 16'h0004);

    // R3 parity error, then R7 halt at frame end
    wr(0, 16'h0001);
    pulse(0);
    exp_reg(1, 16'h0002, "R3 parity sets system error, not yet halted");
    exp_reg(0, 16'h0000, "R3 run cleared by parity");
    exp_sig(1, 1'b1, "R4 irq from system error");
    pulse(4);
    exp_reg(1, 16'h000A, "R7 halted at frame end");
    wr(1, 16'h0002);

    // R3 master abort and target abort
    wr(0, 16'h0001);
    pulse(1);
    exp_reg(0, 16'h0000, "R3 run cleared by master abort");
    pulse(4);
    wr(1, 16'h0002);
    wr(0, 16'h0001);
    pulse(2);
    exp_reg(1, 16'h0002, "R3 target abort sets system error");
    pulse(4);
    wr(1, 16'h0002);
    exp_reg(1, 16'h0008, "R6 system error cleared");

    // R5 resume while suspended, masked then enabled
    wr(0, 16'h0002);
    pulse(3);
    exp_reg(1, 16'h0009, "R5 resume recorded in suspend");
    exp_sig(1, 1'b0, "R5 masked resume no irq");
    wr(2, 16'h0001);
    exp_sig(1, 1'b1, "R5 enabled resume raises irq");
    wr(1, 16'h0001);
    wr(0, 16'h0000);
    pulse(3);
    exp_reg(1, 16'h0008, "R5 resume ignored without suspend");

    // R9 port state, low-speed hold and wake
    port_ls = 2'b01;
    wr(3, 16'h0009);
    port_ls = 2'b00;
    @(negedge clk);
    exp_reg(3, 16'h000D, "R9 low-speed held while suspended");
    exp_sig(2, 1'b0, "R9 no wake before resume");
    pulse(5);
    exp_sig(2, 1'b1, "R9 wake request");
    exp_reg(3, 16'h000F, "R9 port resume bit");
    exp_reg(1, 16'h0018, "R9 wake status");

    // R8 retention across main reset
    wr(0, 16'h0002);
    pulse(3);
    exp_reg(1, 16'h0019, "R8 status before main reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_reg(0, 16'h0002, "R8 suspend kept over main reset");
    exp_reg(1, 16'h0019, "R8 status kept over main reset");
    exp_reg(3, 16'h000F, "R8 port kept over main reset");
    exp_sig(1, 1'b0, "R8 enable lost so irq low");
    pwr_rst = 1'b1;
    @(negedge clk);
    pwr_rst = 1'b0;
    exp_reg(0, 16'h0000, "R8 power reset clears command");
    exp_reg(1, 16'h0008, "R8 power reset clears status");
    exp_reg(3, 16'h0000, "R8 power reset clears port");
    exp_sig(2, 1'b0, "R8 power reset clears wake");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule